// File: doc/BRIEF.md
# Programmable Interval Timer

A 32-bit up-counting interval timer for a processor's system register space. A free-running tick enable advances the count while the timer is running. The nominal tick rate is 1 MHz, so one count is one microsecond. When the count passes all ones, the timer sets a done flag and reloads itself from a reload register. It can also raise an interrupt. If an overflow arrives while done is still pending, an error flag records the overrun.

Software reaches three registers through a single-cycle write port and a combinational read port:

- **Control/status register (address 0).** It holds:
  - the run and interrupt-enable controls;
  - the done and error flags, which are cleared by writing a one;
  - two write-only action bits. One copies the reload value into the counter. The other single-steps the counter while the timer is stopped.
- **Count register (address 1).** Read-only.
- **Reload register (address 2).**

Address 3 reads as zero. The interrupt output is a level that stays up until software clears done or interrupt-enable.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero and irq_o is low.
- R2: A control read (address 0) returns only error at bit 31, done at bit 7, interrupt-enable at bit 6 and run at bit 0. Transfer (bit 4) and step (bit 5) always read as zero. Address 3 reads as zero.
- R3: A tick with run set and no write in that cycle adds one to the count. A tick with run clear leaves the count unchanged.
- R4: A tick that finds the count at all ones and run set loads the count from the reload register and sets done.
- R5: An overflow that occurs while done is already set also sets error. Done stays set.
- R6: A control write clears error if bit 31 is one, and clears done if bit 7 is one. A zero in either bit leaves that flag unchanged. Interrupt-enable and run take the values written to bits 6 and 0.
- R7: A control write with bit 4 set copies the reload register into the count.
- R8: A control write with bit 5 set and bit 0 clear adds one to the count. This is applied after any transfer requested in the same write. If the step wraps the count to zero, the count reloads from the reload register and the step counts as an overflow. With bit 0 set, bit 5 has no effect.
- R9: irq_o rises only at an overflow, and only when interrupt-enable is set at that point. It falls as soon as done or interrupt-enable is cleared. Setting interrupt-enable while done is already pending does not raise irq_o.
- R10: Writes to the count address are ignored.
- R11: A register write in the same cycle as a tick suppresses that tick.
- R12: The reload register stores the low CNT_W bits written to address 2 and reads them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable, nominally 1 MHz |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 count, 2 reload, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the timer with CNT_W = 8, so a full interval is at most 256 ticks. Reload values near all ones bring overflows within a few ticks. This puts back-to-back overflows, the overrun-to-error path, and single-step wraparound within a short run. A pseudo-random phase then mixes ticks with control, reload and ignored count writes, many of them colliding with a tick. The count and flag update rules are the same at any width, so the narrow build checks the same rules as the 32-bit default.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_ERR  = 31;
  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_STEP = 5;
  localparam int unsigned BIT_XFER = 4;
  localparam int unsigned BIT_RUN  = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CUR  = 2'd1,
    ADDR_NEXT = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic err;
    logic done;
    logic ie;
    logic run;
  } stat_t;

  // control write fields, sliced once at the top
  typedef struct packed {
    logic err;
    logic done;
    logic ie;
    logic step;
    logic xfer;
    logic run;
  } ctrl_wr_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
(
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       xfer_bit_i,
  input  logic       step_bit_i,
  input  logic       run_bit_i,
  output logic       ctrl_we_o,
  output logic       next_we_o,
  output logic       xfer_o,
  output logic       step_o,
  output logic       adv_o
);
  always_comb begin
    ctrl_we_o = wr_en_i && (addr_i == ADDR_CTRL);
    next_we_o = wr_en_i && (addr_i == ADDR_NEXT);
    xfer_o    = ctrl_we_o && xfer_bit_i;
    // step only acts while the written run bit is clear
    step_o    = ctrl_we_o && step_bit_i && !run_bit_i;
    // any write wins over a coincident tick
    adv_o     = tick_i && run_i && !wr_en_i;
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             step_i,
  input  logic             xfer_i,
  input  logic             next_we_i,
  input  logic [CNT_W-1:0] next_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, next_q, base;
  logic             inc;

  always_comb begin
    base   = xfer_i ? next_q : cnt_q;
    inc    = adv_i || step_i;
    wrap_o = inc && (&base);
    cnt_d  = base;
    if (inc) cnt_d = wrap_o ? next_q : base + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      next_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (next_we_i) next_q <= next_wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign next_o = next_q;
endmodule

// File: rtl/itmr_status.sv
module itmr_status
  import itmr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_we_i,
  input  logic  err_bit_i,
  input  logic  done_bit_i,
  input  logic  ie_bit_i,
  input  logic  run_bit_i,
  input  logic  wrap_i,
  output stat_t stat_o,
  output logic  irq_o
);
  stat_t q, d;
  logic  irq_q, irq_d;
  logic  done_kept, err_kept;

  always_comb begin
    done_kept = q.done && !(ctrl_we_i && done_bit_i);
    err_kept  = q.err  && !(ctrl_we_i && err_bit_i);
    d.ie      = ctrl_we_i ? ie_bit_i  : q.ie;
    d.run     = ctrl_we_i ? run_bit_i : q.run;
    d.done    = done_kept || wrap_i;
    d.err     = err_kept || (wrap_i && done_kept);
    // request only raised by an overflow, dropped once done&ie break
    irq_d     = wrap_i ? d.ie : (irq_q && d.done && d.ie);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      irq_q <= 1'b0;
    end else begin
      q     <= d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [1:0]       addr_i,
  input  stat_t            stat_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] next_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic [REG_W-1:0] cnt_ext, next_ext;

  if (PAD_W == 0) begin : g_full
    assign cnt_ext  = cnt_i;
    assign next_ext = next_i;
  end else begin : g_pad
    assign cnt_ext  = {{PAD_W{1'b0}}, cnt_i};
    assign next_ext = {{PAD_W{1'b0}}, next_i};
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_ERR]  = stat_i.err;
        rdata_o[BIT_DONE] = stat_i.done;
        rdata_o[BIT_IE]   = stat_i.ie;
        rdata_o[BIT_RUN]  = stat_i.run;
      end
      ADDR_CUR:  rdata_o = cnt_ext;
      ADDR_NEXT: rdata_o = next_ext;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  ctrl_wr_t         wf;
  stat_t            stat;
  logic [CNT_W-1:0] cnt, next_val;
  logic             ctrl_we, next_we, xfer, step, adv, wrap;

  always_comb begin
    wf.err  = wdata_i[BIT_ERR];
    wf.done = wdata_i[BIT_DONE];
    wf.ie   = wdata_i[BIT_IE];
    wf.step = wdata_i[BIT_STEP];
    wf.xfer = wdata_i[BIT_XFER];
    wf.run  = wdata_i[BIT_RUN];
  end

  itmr_decode u_decode (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .tick_i     (tick_i),
    .run_i      (stat.run),
    .xfer_bit_i (wf.xfer),
    .step_bit_i (wf.step),
    .run_bit_i  (wf.run),
    .ctrl_we_o  (ctrl_we),
    .next_we_o  (next_we),
    .xfer_o     (xfer),
    .step_o     (step),
    .adv_o      (adv)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .step_i       (step),
    .xfer_i       (xfer),
    .next_we_i    (next_we),
    .next_wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o        (cnt),
    .next_o       (next_val),
    .wrap_o       (wrap)
  );

  itmr_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .err_bit_i  (wf.err),
    .done_bit_i (wf.done),
    .ie_bit_i   (wf.ie),
    .run_bit_i  (wf.run),
    .wrap_i     (wrap),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  itmr_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .addr_i  (addr_i),
    .stat_i  (stat),
    .cnt_i   (cnt),
    .next_i  (next_val),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input ctrl_wr_t         wf_i,
  input stat_t            stat_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] next_i,
  input logic             irq_i
);
  logic ctrl_wr, run_tick;
  assign ctrl_wr  = wr_en_i && (addr_i == ADDR_CTRL);
  assign run_tick = tick_i && stat_i.run && !wr_en_i;

  // R9
  irq_needs_done_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (stat_i.done && stat_i.ie));

  // R3
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stat_i.run && !wr_en_i) |=> $stable(cnt_i));

  // R3
  run_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tick && !(&cnt_i)) |=> (cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1))));

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tick && (&cnt_i)) |=> ((cnt_i == $past(next_i)) && stat_i.done));

  // R5
  overrun_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tick && (&cnt_i) && stat_i.done) |=> stat_i.err);

  // R10
  cur_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CUR) |=> $stable(cnt_i));

  // R11
  write_beats_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tick_i && addr_i == ADDR_NEXT) |=> $stable(cnt_i));

  // R6
  done_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wf_i.done && (wf_i.run || !wf_i.step)) |=> !stat_i.done);

  // R6
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wf_i.err && (wf_i.run || !wf_i.step)) |=> !stat_i.err);

  // R6
  ie_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (stat_i.ie == $past(wf_i.ie)));

  // R7
  xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wf_i.xfer && (wf_i.run || !wf_i.step)) |=> (cnt_i == $past(next_i)));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wf_i    (wf),
  .stat_i  (stat),
  .cnt_i   (cnt),
  .next_i  (next_val),
  .irq_i   (irq_o)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int m_cnt = 0, m_next = 0;
  bit m_err = 0, m_done = 0, m_ie = 0, m_run = 0, m_irq = 0;

  always #4 clk = ~clk;

  interval_timer #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: exp_rd = {m_err, 23'd0, m_done, m_ie, 5'd0, m_run};
      1: exp_rd = 32'(m_cnt);
      2: exp_rd = 32'(m_next);
      default: exp_rd = 32'd0;
    endcase
  endfunction

  task automatic overflow_event();
    if (m_done) m_err = 1;
    m_done = 1;
    m_cnt = m_next;
    m_irq = m_ie;
  endtask

  task automatic model_update(input bit w, input logic [1:0] a, input logic [31:0] d, input bit t);
    if (w) begin
      if (a == 2'd0) begin
        int c;
        bit wr;
        wr = 0;
        if (d[31]) m_err = 0;
        if (d[7]) m_done = 0;
        m_ie = d[6];
        m_run = d[0];
        c = d[4] ? m_next : m_cnt;
        if (d[5] && !d[0]) begin
          c = c + 1;
          if (c > MAXV) wr = 1;
        end
        m_cnt = c;
        if (wr) overflow_event();
        else m_irq = m_irq && m_done && m_ie;
      end else if (a == 2'd2) begin
        m_next = int'(d) & MAXV;
      end
    end else if (t && m_run) begin
      if (m_cnt == MAXV) overflow_event();
      else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // samples from just after the falling edge, before the next rising edge
  task automatic compare(input string tag);
    check(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    for (int k = 0; k < 3; k++) begin
      addr = 2'(k);
      #1;
      check(tag, $sformatf("reg%0d", k), rdata, exp_rd(k));
    end
  endtask

  task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d, input bit t, input string tag);
    wr_en = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_update(w, a, d, t);
    @(negedge clk);
    wr_en = 0; tick = 0;
    compare(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 32'd0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R12 reload register, upper bits dropped
    cyc(1, 2'd2, 32'hABCD_12F0, 0, "R12");
    // R7 transfer while stopped
    cyc(1, 2'd0, 32'h0000_0010, 0, "R7");
    // R3 stopped ticks do nothing
    ticks(5, "R3");
    // R6 set run and ie, R2 transfer/step bits read zero
    cyc(1, 2'd0, 32'h0000_0041, 0, "R2");
    // R3 R4 R9 count to overflow
    ticks(20, "R4");
    // R5 second overflow while done pending
    ticks(16, "R5");
    // R10 R11 count write with tick
    cyc(1, 2'd1, 32'h0000_0055, 1, "R10");
    cyc(1, 2'd2, 32'h0000_00F8, 1, "R11");
    // R6 R9 clear done keeping run/ie, irq drops
    cyc(1, 2'd0, 32'h0000_00C1, 0, "R9");
    cyc(1, 2'd0, 32'h8000_0041, 0, "R6");
    ticks(3, "R3");
    // R8 stop, then step to the wrap
    cyc(1, 2'd0, 32'h0000_0000, 0, "R8");
    cyc(1, 2'd2, 32'h0000_00FE, 0, "R12");
    cyc(1, 2'd0, 32'h0000_0030, 0, "R8");
    cyc(1, 2'd0, 32'h0000_0020, 0, "R8");
    cyc(1, 2'd0, 32'h0000_0020, 0, "R8");
    // R9 enabling with done pending raises nothing
    cyc(1, 2'd0, 32'h0000_0040, 0, "R9");
    // R8 step ignored while run written set
    cyc(1, 2'd0, 32'h0000_0061, 0, "R8");
    ticks(4, "R4");
    // R2 reserved address
    @(negedge clk);
    addr = 2'd3;
    #1;
    check("R2", "reg3", rdata, 32'd0);

    seed = 32'h1234_5677;
    for (int i = 0; i < 3000; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'h7FFF;
      case (r % 10)
        0, 1, 2, 3, 4: cyc(0, 2'd0, 32'd0, 1, "R3");
        5: cyc(1, 2'd2, 32'(32'hFFFF_FFF0 | (r >> 4)), (r >> 3) & 1, "R12");
        6: cyc(1, 2'd0, 32'((r & 32'h00F1) | ((r & 32'h0100) << 23) | 32'h1), (r >> 9) & 1, "R6");
        7: cyc(1, 2'd0, 32'((r >> 2) & 32'h00F0), 0, "R8");
        8: cyc(1, 2'd1, 32'(r), 1, "R10");
        default: cyc(0, 2'd0, 32'd0, 0, "R3");
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule